// File: doc/BRIEF.md
# Shifter with Normalize and Exponent Detect

This block is the shift unit of a 16-bit fixed-point datapath. Each cycle it can take one operand, an 8-bit signed shift code, an opcode and a half-select. From these it computes a logical or arithmetic shift, a normalize step, a denormalize step or an exponent. The operand is first placed in the upper or lower half of a 32-bit field and then shifted. The 32-bit result is held in a register. An OR-merge option lets two 16-bit words be assembled into one 32-bit value over two cycles, which supports multiword shifts and double-precision normalization.

The exponent of an operand is the negated count of its redundant sign bits. A block-exponent register follows a series of operands and keeps the exponent of the one with the least headroom. After a pass over a data block it holds the common shift that normalizes the whole block, which supports block floating-point. All outputs are registered and change one clock after the opcode is presented.

Top module: `shf_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0, `exp_out` becomes 0 and `blk_exp` becomes -15.
- R2: Opcode 1 (logical shift) places the operand as `{operand,16'h0}` when `place_hi`=1, or as `{16'h0,operand}` when `place_hi`=0. A positive shift code shifts the placed value left and a negative code shifts it right, with zeros filled in.
- R3: Opcode 2 (arithmetic shift) places the operand as `{operand,16'h0}` when `place_hi`=1, or sign-extended to 32 bits when `place_hi`=0. A negative code shifts right and fills with bit 31 of the placed value. A positive code shifts left with zero fill.
- R4: A shift magnitude of 32 or more gives a zero result for any left shift and for any zero-filled right shift. It gives 32 copies of the fill bit for a sign-filled right shift.
- R5: Opcode 3 (normalize) treats the shift code as an exponent and shifts left by its negation. The operand is placed as `{operand,16'h0}` when `place_hi`=1, or as `{16'h0,operand}` when `place_hi`=0.
- R6: Opcode 4 (denormalize) shifts by the code itself, so a negative exponent shifts right. The fill is the sign bit when `place_hi`=1 and zero when `place_hi`=0.
- R7: Opcode 5 (derive exponent) sets `exp_out` to minus the number of bits below bit 15 that equal bit 15 before the first differing bit. The value lies in 0..-15, and 0x0000 and 0xFFFF give -15. `result` is left unchanged.
- R8: Opcode 6 (block exponent) does what opcode 5 does and also raises `blk_exp` to the new exponent when the new exponent is larger, meaning it has less headroom. Opcode 7 sets `blk_exp` back to -15. No other opcode changes `blk_exp`.
- R9: When `merge`=1 on a shift opcode (1 to 4), the new result is the bitwise OR of the shifted value and the previous `result`.
- R10: Opcode 0 (no operation) leaves all outputs unchanged. For every opcode the outputs take their new values at the clock edge that samples the opcode. `exp_out` changes only on opcodes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Opcode (0 nop, 1 logical, 2 arithmetic, 3 normalize, 4 denormalize, 5 exponent, 6 block exponent, 7 block clear) |
| operand | input | 16 | Data operand |
| shift_code | input | 8 | Signed shift count or exponent |
| place_hi | input | 1 | Place operand in upper half (1) or lower half (0) |
| merge | input | 1 | OR the shifted value into the previous result |
| result | output | 32 | Registered 32-bit result |
| exp_out | output | 5 | Last derived exponent, signed |
| blk_exp | output | 5 | Block exponent, signed |

## Verification
The bound checker checks the following on every cycle:
- the block exponent never falls except on a clear, and a clear always lands on -15;
- both exponents stay within 0..-15;
- the result register holds on non-shift opcodes, and a merge never drops a bit that was already set;
- `exp_out` holds on opcodes that do not derive an exponent.

The exact shifted bit patterns can only be shown by the bench's scenarios and the behavioural model it runs beside the design:
- sign fill against zero fill at each half placement;
- saturation beyond 31 positions;
- the negated count used by normalize;
- the per-operand exponent values.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W  = 16;
    localparam int CODE_W  = 8;

    typedef enum logic [2:0] {
        SHF_NOP    = 3'd0,
        SHF_LSH    = 3'd1,
        SHF_ASH    = 3'd2,
        SHF_NORM   = 3'd3,
        SHF_DENORM = 3'd4,
        SHF_EXP    = 3'd5,
        SHF_BEXP   = 3'd6,
        SHF_BCLR   = 3'd7
    } shf_op_e;

    // Control word steering placement, direction and fill of one shift
    typedef struct packed {
        logic do_shift;   // opcode writes the result register
        logic sext;       // sign-extend a low-half placement
        logic negate;     // use the negated code as the shift amount
        logic fill_sign;  // right shift fills with bit 31 of placed value
    } shf_ctl_t;

    function automatic shf_ctl_t shf_decode(shf_op_e op, logic hi);
        shf_ctl_t c;
        c = '0;
        unique case (op)
            SHF_LSH: c.do_shift = 1'b1;
            SHF_ASH: begin
                c.do_shift  = 1'b1;
                c.sext      = ~hi;
                c.fill_sign = 1'b1;
            end
            SHF_NORM: begin
                c.do_shift  = 1'b1;
                c.negate    = 1'b1;
                c.fill_sign = hi;
            end
            SHF_DENORM: begin
                c.do_shift  = 1'b1;
                c.fill_sign = hi;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_exp_op(shf_op_e op);
        return (op == SHF_EXP) || (op == SHF_BEXP);
    endfunction

endpackage

// File: rtl/shf_place.sv
module shf_place #(
    parameter int DW = 16,
    localparam int RW = 2 * DW
) (
    input  logic [DW-1:0] din,
    input  logic          hi,
    input  logic          sext,
    output logic [RW-1:0] dout
);
    always_comb begin
        if (hi)
            dout = {din, {DW{1'b0}}};
        else if (sext)
            dout = {{DW{din[DW-1]}}, din};
        else
            dout = {{DW{1'b0}}, din};
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int RW = 32,
    parameter int AW = 9,
    localparam int LG = $clog2(RW)
) (
    input  logic [RW-1:0]        din,
    input  logic signed [AW-1:0] amt,
    input  logic                 fill,
    output logic [RW-1:0]        dout
);
    logic          go_left;
    logic [AW-1:0] mag;
    logic          too_far;
    logic [RW-1:0] lstage [LG+1];
    logic [RW-1:0] rstage [LG+1];

    assign go_left = ~amt[AW-1];
    assign mag     = go_left ? amt : -amt;
    assign too_far = (mag >= AW'(RW));

    assign lstage[0] = din;
    assign rstage[0] = din;

    for (genvar k = 0; k < LG; k++) begin : g_stage
        localparam int S = 1 << k;
        assign lstage[k+1] = mag[k] ? {lstage[k][RW-1-S:0], {S{1'b0}}} : lstage[k];
        assign rstage[k+1] = mag[k] ? {{S{fill}}, rstage[k][RW-1:S]} : rstage[k];
    end

    always_comb begin
        if (too_far)
            dout = go_left ? '0 : {RW{fill}};
        else
            dout = go_left ? lstage[LG] : rstage[LG];
    end
endmodule

// File: rtl/shf_expdet.sv
module shf_expdet #(
    parameter int DW = 16,
    localparam int EW = $clog2(DW) + 1
) (
    input  logic [DW-1:0]        din,
    output logic signed [EW-1:0] expo
);
    logic [EW-1:0] run_len;
    logic          running;

    always_comb begin
        run_len = '0;
        running = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (running && (din[i] == din[DW-1]))
                run_len = run_len + 1'b1;
            else
                running = 1'b0;
        end
        expo = -$signed(run_len);
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = CODE_W,
    localparam int RW = 2 * DW,
    localparam int EW = $clog2(DW) + 1,
    localparam int AW = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           op,
    input  logic [DW-1:0]        operand,
    input  logic signed [SW-1:0] shift_code,
    input  logic                 place_hi,
    input  logic                 merge,
    output logic [RW-1:0]        result,
    output logic signed [EW-1:0] exp_out,
    output logic signed [EW-1:0] blk_exp
);
    localparam logic signed [EW-1:0] BLK_START = EW'(-(DW - 1));

    shf_op_e               op_e;
    shf_ctl_t              ctl;
    logic [RW-1:0]         placed;
    logic [RW-1:0]         shifted;
    logic signed [AW-1:0]  amt_code;
    logic signed [AW-1:0]  amt;
    logic                  fill;
    logic signed [EW-1:0]  new_exp;

    assign op_e     = shf_op_e'(op);
    assign ctl      = shf_decode(op_e, place_hi);
    assign amt_code = AW'(shift_code);
    assign amt      = ctl.negate ? -amt_code : amt_code;

    shf_place #(.DW(DW)) u_place (
        .din  (operand),
        .hi   (place_hi),
        .sext (ctl.sext),
        .dout (placed)
    );

    assign fill = ctl.fill_sign & placed[RW-1];

    shf_barrel #(.RW(RW), .AW(AW)) u_barrel (
        .din  (placed),
        .amt  (amt),
        .fill (fill),
        .dout (shifted)
    );

    shf_expdet #(.DW(DW)) u_expdet (
        .din  (operand),
        .expo (new_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            exp_out <= '0;
            blk_exp <= BLK_START;
        end else begin
            if (ctl.do_shift)
                result <= merge ? (result | shifted) : shifted;
            if (is_exp_op(op_e))
                exp_out <= new_exp;
            if (op_e == SHF_BEXP && new_exp > blk_exp)
                blk_exp <= new_exp;
            else if (op_e == SHF_BCLR)
                blk_exp <= BLK_START;
        end
    end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk
    import shf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = CODE_W,
    localparam int RW = 2 * DW,
    localparam int EW = $clog2(DW) + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           op,
    input logic [DW-1:0]        operand,
    input logic                 merge,
    input logic [RW-1:0]        result,
    input logic signed [EW-1:0] exp_out,
    input logic signed [EW-1:0] blk_exp
);
    localparam logic signed [EW-1:0] LOWEST = EW'(-(DW - 1));

    logic shift_op;
    logic hold_op;
    assign shift_op = (op >= 3'(SHF_LSH)) && (op <= 3'(SHF_DENORM));
    assign hold_op  = !shift_op;

    // R8
    blk_rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (op != 3'(SHF_BCLR)) |=> (blk_exp >= $past(blk_exp)));

    // R8
    blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'(SHF_BCLR)) |=> (blk_exp == LOWEST));

    // R7
    exp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (exp_out <= 0) && (exp_out >= LOWEST) && (blk_exp <= 0) && (blk_exp >= LOWEST));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold_op |=> $stable(result));

    // R7
    zero_exp_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == 3'(SHF_EXP)) && (operand == '0)) |=> (exp_out == LOWEST));

    // R9
    merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_op && merge) |=> ((result & $past(result)) == $past(result)));

    // R10
    exp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((op != 3'(SHF_EXP)) && (op != 3'(SHF_BEXP))) |=> $stable(exp_out));
endmodule

bind shf_unit shf_unit_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .operand (operand),
    .merge   (merge),
    .result  (result),
    .exp_out (exp_out),
    .blk_exp (blk_exp)
);

// File: tb/shf_unit_test.sv
module shf_unit_test;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        op = 3'd0;
    logic [15:0]       operand = '0;
    logic signed [7:0] shift_code = '0;
    logic              place_hi = 1'b0;
    logic              merge = 1'b0;
    logic [31:0]       result;
    logic signed [4:0] exp_out;
    logic signed [4:0] blk_exp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [31:0] m_res;
    int        m_exp;
    int        m_blk;

    always #2 clk = ~clk;

    shf_unit uut (
        .clk(clk), .rst(rst), .op(op), .operand(operand),
        .shift_code(shift_code), .place_hi(place_hi), .merge(merge),
        .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
    );

    function automatic int ref_exp(bit [15:0] d);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (d[i] != d[15]) break;
            n++;
        end
        return -n;
    endfunction

    function automatic bit [31:0] ref_shift(int o, bit [15:0] d, int c, bit hi);
        bit [31:0] v;
        bit        f;
        int        a;
        int        m;
        bit [31:0] r;
        if (hi) v = {d, 16'h0000};
        else if (o == 2) v = 32'($signed(d));
        else v = {16'h0000, d};
        if (o == 2) f = v[31];
        else if (o == 3 || o == 4) f = hi & v[31];
        else f = 1'b0;
        a = (o == 3) ? -c : c;
        if (a >= 0) begin
            if (a >= 32) return 32'h0;
            return v << a;
        end
        m = -a;
        if (m >= 32) return f ? 32'hFFFF_FFFF : 32'h0;
        r = v >> m;
        if (f) r = r | ~(32'hFFFF_FFFF >> m);
        return r;
    endfunction

    task automatic compare(string tag);
        checks++;
        if (result !== m_res || int'(exp_out) != m_exp || int'(blk_exp) != m_blk) begin
            errors++;
            $display("FAIL %s: actual res=%h exp=%0d blk=%0d expected res=%h exp=%0d blk=%0d",
                     tag, result, exp_out, blk_exp, m_res, m_exp, m_blk);
        end
    endtask

    task automatic step(int o, bit [15:0] d, int c, bit hi, bit mg, string tag);
        bit [31:0] sv;
        int        e;
        op = 3'(o); operand = d; shift_code = 8'(c); place_hi = hi; merge = mg;
        case (o)
            1, 2, 3, 4: begin
                sv = ref_shift(o, d, c, hi);
                m_res = mg ? (m_res | sv) : sv;
            end
            5: m_exp = ref_exp(d);
            6: begin
                e = ref_exp(d);
                m_exp = e;
                if (e > m_blk) m_blk = e;
            end
            7: m_blk = -15;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic expect_exp(int want, string tag);
        checks++;
        if (int'(exp_out) != want) begin
            errors++;
            $display("FAIL %s: exponent actual %0d expected %0d", tag, exp_out, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tags [8];
        tags = '{"R10", "R2", "R3", "R5", "R6", "R7", "R8", "R8"};
        m_res = 0; m_exp = 0; m_blk = -15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R2 logical placement and direction
        step(1, 16'h8001, 4, 1'b0, 1'b0, "R2");
        step(1, 16'h8001, -3, 1'b1, 1'b0, "R2");
        step(1, 16'hF00F, -20, 1'b1, 1'b0, "R2");
        // R3 arithmetic
        step(2, 16'h8001, -4, 1'b0, 1'b0, "R3");
        step(2, 16'h9000, -8, 1'b1, 1'b0, "R3");
        step(2, 16'h1234, 5, 1'b0, 1'b0, "R3");
        // R4 saturation
        step(2, 16'h8000, -40, 1'b1, 1'b0, "R4");
        step(2, 16'h7FFF, -32, 1'b0, 1'b0, "R4");
        step(1, 16'hFFFF, 32, 1'b0, 1'b0, "R4");
        step(1, 16'hFFFF, -33, 1'b1, 1'b0, "R4");
        // R5 normalize and R9 double-word assembly
        step(3, 16'h0012, -8, 1'b1, 1'b0, "R5");
        step(3, 16'h8040, -8, 1'b0, 1'b1, "R9");
        step(3, 16'hFF80, 8, 1'b1, 1'b0, "R5");
        // R6 denormalize
        step(4, 16'h8400, -3, 1'b1, 1'b0, "R6");
        step(4, 16'h8400, -3, 1'b0, 1'b1, "R6");
        // R7 exponent values
        step(5, 16'h0001, 0, 1'b0, 1'b0, "R7"); expect_exp(-14, "R7");
        step(5, 16'h4000, 0, 1'b0, 1'b0, "R7"); expect_exp(0, "R7");
        step(5, 16'hFFFF, 0, 1'b0, 1'b0, "R7"); expect_exp(-15, "R7");
        step(5, 16'h0000, 0, 1'b0, 1'b0, "R7"); expect_exp(-15, "R7");
        step(5, 16'hFC00, 0, 1'b0, 1'b0, "R7"); expect_exp(-5, "R7");
        // R8 block exponent tracking and clear
        step(6, 16'h0003, 0, 1'b0, 1'b0, "R8");
        step(6, 16'h0100, 0, 1'b0, 1'b0, "R8");
        step(6, 16'h0001, 0, 1'b0, 1'b0, "R8");
        step(7, 16'h0000, 0, 1'b0, 1'b0, "R8");
        step(6, 16'hFFF0, 0, 1'b0, 1'b0, "R8");
        // R10 nop holds
        step(0, 16'hABCD, 5, 1'b1, 1'b1, "R10");
        step(0, 16'h1111, -5, 1'b0, 1'b0, "R10");

        for (int i = 0; i < 4000; i++) begin
            int  o;
            int  c;
            bit  mg;
            o  = $urandom_range(0, 7);
            c  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) - 128
                                             : $urandom_range(0, 80) - 40;
            mg = ($urandom_range(0, 3) == 0);
            step(o, 16'($urandom), c, 1'($urandom), mg,
                 (mg && o >= 1 && o <= 4) ? "R9" : tags[o]);
        end

        op = 3'd0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule